// File: doc/BRIEF.md
# Exception Cause and Vector Unit

This unit sits next to the control logic of a simple processor. It turns unexpected control-flow events into a redirect of the fetch stream. The internal sources are arithmetic overflow, an undefined opcode and a system-call request. A device interrupt arrives from outside the processor. A hardware-fault flag also exists, and its origin is reported by a separate qualifier bit. When any event is accepted, the unit does four things on one clock edge: it saves the program counter of the current instruction, it writes a cause register with an encoded reason, it sets a busy flag, and it issues a redirect target together with a single-cycle valid strobe.

A run-time mode input chooses how the target is formed. In vectored dispatch each cause has its own entry point, and neighbouring entries are 32 bytes (eight 4-byte instructions) apart. In common dispatch every cause goes to one shared entry address, and the handler reads the cause register to find the reason. A return-from-exception strobe sends fetch back to the saved address and clears the busy flag. While the unit is busy, device interrupts are held off. Internal exceptions are always accepted.

Top module: `exc_vector_unit`

## Requirements
- R1: After reset, `redir_valid`, `busy`, `redir_pc`, `saved_pc` and `cause` are all zero.
- R2: When several events are present in the same cycle, exactly one is accepted, in the priority order hardware fault > undefined instruction > overflow > system call > device interrupt. The cause codes are 4, 3, 2, 1 and 0 respectively.
- R3: On acceptance, `cause[2:0]` receives the code and `cause[3]` receives the origin. The origin is 1 for a device interrupt, `fault_ext` for a hardware fault, and 0 for the other sources.
- R4: On acceptance, `saved_pc` receives the `cur_pc` value that was present in the accepting cycle.
- R5: With `vec_mode`=1, the target is `VEC_BASE + code*32`.
- R6: With `vec_mode`=0, the target is `COMMON_ENTRY` for every cause.
- R7: A device interrupt is accepted only when `irq_en`=1 and `busy`=0. Otherwise it is ignored: there is no strobe, and `saved_pc`, `cause` and `busy` keep their values.
- R8: `redir_valid` is high for exactly the cycle after each cycle in which an event or a return is accepted, and low after every other cycle. The registers change on that same edge.
- R9: A return with no event present sets `redir_pc` to `saved_pc`, raises `redir_valid` and clears `busy`. It leaves `saved_pc` and `cause` unchanged.
- R10: If an accepted event and a return occur in the same cycle, the event wins. The return is dropped and `busy` stays set.
- R11: Every accepted event sets `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_irq | input | 1 | Device interrupt request |
| ev_syscall | input | 1 | System-call instruction |
| ev_ovf | input | 1 | Arithmetic overflow |
| ev_undef | input | 1 | Undefined instruction |
| ev_fault | input | 1 | Hardware fault |
| fault_ext | input | 1 | Hardware fault comes from outside the processor |
| irq_en | input | 1 | Global device-interrupt enable |
| vec_mode | input | 1 | 1 selects vectored dispatch, 0 selects common entry |
| eret | input | 1 | Return-from-exception strobe |
| cur_pc | input | AW | Address of the current instruction |
| redir_valid | output | 1 | One-cycle redirect strobe |
| redir_pc | output | AW | Redirect target |
| saved_pc | output | AW | Captured instruction address |
| cause | output | 4 | {origin, code} |
| busy | output | 1 | Handler in progress |

## Verification
Two functions can fall in the same cycle: acceptance of an event and a return from exception. A device interrupt can also meet a return while the unit is busy. Directed steps assert `eret` together with an overflow, which must win and keep `busy` set. They also assert `eret` together with a held interrupt, which must be blocked for that cycle and accepted on the following one. A randomized phase then drives all event lines, the mode and the return strobe at once. A behavioural model applies the priority and blocking rules, and its result is compared with every output on every clock.

// File: rtl/exc_vector_unit.sv
module exc_vector_unit #(
  parameter int AW = 32,
  parameter logic [AW-1:0] VEC_BASE = 32'h0000_0200,
  parameter logic [AW-1:0] COMMON_ENTRY = 32'h0000_0180,
  parameter int VEC_STRIDE = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_irq,
  input  logic          ev_syscall,
  input  logic          ev_ovf,
  input  logic          ev_undef,
  input  logic          ev_fault,
  input  logic          fault_ext,
  input  logic          irq_en,
  input  logic          vec_mode,
  input  logic          eret,
  input  logic [AW-1:0] cur_pc,
  output logic          redir_valid,
  output logic [AW-1:0] redir_pc,
  output logic [AW-1:0] saved_pc,
  output logic [3:0]    cause,
  output logic          busy
);
  localparam int SH = $clog2(VEC_STRIDE);

  logic          irq_ok, any_int, take;
  logic [2:0]    code;
  logic          origin;
  logic [AW-1:0] target;

  assign irq_ok  = ev_irq & irq_en & ~busy;
  assign any_int = ev_fault | ev_undef | ev_ovf | ev_syscall;
  assign take    = any_int | irq_ok;

  always_comb begin
    code = 3'd0;
    origin = 1'b1;
    if (ev_fault) begin
      code = 3'd4; origin = fault_ext;
    end else if (ev_undef) begin
      code = 3'd3; origin = 1'b0;
    end else if (ev_ovf) begin
      code = 3'd2; origin = 1'b0;
    end else if (ev_syscall) begin
      code = 3'd1; origin = 1'b0;
    end
  end

  assign target = vec_mode ? VEC_BASE + (AW'(code) << SH) : COMMON_ENTRY;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redir_valid <= 1'b0;
      redir_pc    <= '0;
      saved_pc    <= '0;
      cause       <= '0;
      busy        <= 1'b0;
    end else if (take) begin
      redir_valid <= 1'b1;
      redir_pc    <= target;
      saved_pc    <= cur_pc;
      cause       <= {origin, code};
      busy        <= 1'b1;
    end else if (eret) begin
      redir_valid <= 1'b1;
      redir_pc    <= saved_pc;
      busy        <= 1'b0;
    end else begin
      redir_valid <= 1'b0;
    end
  end

  a_r4_pc_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovf |=> saved_pc == $past(cur_pc));

  a_r5_fault_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fault && vec_mode) |=> (redir_pc == VEC_BASE + (AW'(4) << SH)) && cause[2:0] == 3'd4);

  a_r6_common_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_undef && !vec_mode) |=> redir_pc == COMMON_ENTRY);

  a_r7_irq_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_irq && (!irq_en || busy) && !ev_fault && !ev_undef && !ev_ovf && !ev_syscall && !eret)
      |=> !redir_valid && $stable(cause) && $stable(saved_pc));

  a_r9_return: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && !ev_irq && !ev_fault && !ev_undef && !ev_ovf && !ev_syscall)
      |=> redir_valid && !busy && redir_pc == $past(saved_pc));

  a_r10_event_beats_return: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && ev_syscall) |=> busy && cause[2:0] != 3'd0);

  a_r11_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
    ev_undef |=> busy);
endmodule

// File: tb/exc_vector_unit_tb_top.sv
module exc_vector_unit_tb_top;
  localparam logic [31:0] VB = 32'h0000_0200;
  localparam logic [31:0] CE = 32'h0000_0180;

  logic clk = 0, rst_n = 0;
  logic ev_irq = 0, ev_syscall = 0, ev_ovf = 0, ev_undef = 0, ev_fault = 0;
  logic fault_ext = 0, irq_en = 0, vec_mode = 0, eret = 0;
  logic [31:0] cur_pc = 0;
  logic redir_valid, busy;
  logic [31:0] redir_pc, saved_pc;
  logic [3:0] cause;

  always #10 clk = ~clk;

  exc_vector_unit dut_i (
    .clk(clk), .rst_n(rst_n), .ev_irq(ev_irq), .ev_syscall(ev_syscall), .ev_ovf(ev_ovf),
    .ev_undef(ev_undef), .ev_fault(ev_fault), .fault_ext(fault_ext), .irq_en(irq_en),
    .vec_mode(vec_mode), .eret(eret), .cur_pc(cur_pc), .redir_valid(redir_valid),
    .redir_pc(redir_pc), .saved_pc(saved_pc), .cause(cause), .busy(busy));

  int checks = 0, errors = 0;
  bit done = 0;

  logic        m_valid = 0, m_busy = 0;
  logic [31:0] m_pc = 0, m_saved = 0;
  logic [3:0]  m_cause = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int c;
    bit o;
    bit acc;
    if (!rst_n) begin
      m_valid = 0; m_busy = 0; m_pc = 0; m_saved = 0; m_cause = 0;
    end else begin
      acc = 1;
      if (ev_fault) begin c = 4; o = fault_ext; end
      else if (ev_undef) begin c = 3; o = 0; end
      else if (ev_ovf) begin c = 2; o = 0; end
      else if (ev_syscall) begin c = 1; o = 0; end
      else if (ev_irq && irq_en && !m_busy) begin c = 0; o = 1; end
      else acc = 0;
      if (acc) begin
        m_valid = 1; m_pc = vec_mode ? VB + 32 * c : CE;
        m_saved = cur_pc; m_cause = {o, 3'(c)}; m_busy = 1;
      end else if (eret) begin
        m_valid = 1; m_pc = m_saved; m_busy = 0;
      end else m_valid = 0;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk("R8 redir_valid", 32'(redir_valid), 32'(m_valid));
    chk("R5/R6/R9 redir_pc", redir_pc, m_pc);
    chk("R4 saved_pc", saved_pc, m_saved);
    chk("R3 cause", 32'(cause), 32'(m_cause));
    chk("R11 busy", 32'(busy), 32'(m_busy));
  end

  task automatic drive(input logic [4:0] ev, input logic ext, input logic en,
                       input logic vm, input logic r, input logic [31:0] pc);
    @(negedge clk);
    {ev_fault, ev_undef, ev_ovf, ev_syscall, ev_irq} = ev;
    fault_ext = ext; irq_en = en; vec_mode = vm; eret = r; cur_pc = pc;
    @(posedge clk); #1;
  endtask

  task automatic idle();
    drive(5'b0, 0, 0, 0, 0, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset valid", 32'(redir_valid), 0);
    chk("R1 reset busy", 32'(busy), 0);
    chk("R1 reset pc", redir_pc, 0);
    chk("R1 reset saved", saved_pc, 0);
    chk("R1 reset cause", 32'(cause), 0);
    @(negedge clk) rst_n = 1;

    drive(5'b11111, 1, 1, 1, 0, 32'h1000);
    chk("R2 all events code", 32'(cause), 32'hC);
    chk("R5 fault vector", redir_pc, VB + 128);
    drive(5'b01110, 0, 1, 1, 0, 32'h1004);
    chk("R2 undef over ovf", 32'(cause), 32'h3);
    chk("R5 undef vector", redir_pc, VB + 96);
    drive(5'b00010, 0, 1, 0, 0, 32'h1008);
    chk("R6 syscall common", redir_pc, CE);
    chk("R4 saved", saved_pc, 32'h1008);
    idle();
    chk("R8 strobe drops", 32'(redir_valid), 0);
    drive(5'b00001, 0, 1, 1, 0, 32'h2000);
    chk("R7 irq blocked while busy", 32'(redir_valid), 0);
    chk("R7 saved unchanged", saved_pc, 32'h1008);
    drive(5'b00000, 0, 0, 0, 1, 32'h0);
    chk("R9 return target", redir_pc, 32'h1008);
    chk("R9 busy cleared", 32'(busy), 0);
    drive(5'b00001, 0, 0, 1, 0, 32'h2004);
    chk("R7 irq disabled", 32'(redir_valid), 0);
    drive(5'b00001, 0, 1, 1, 0, 32'h2008);
    chk("R3 irq cause", 32'(cause), 32'h8);
    chk("R5 irq vector", redir_pc, VB);
    drive(5'b00100, 0, 1, 1, 1, 32'h3000);
    chk("R10 event beats return busy", 32'(busy), 1);
    chk("R10 event target", redir_pc, VB + 64);
    drive(5'b00001, 0, 1, 1, 1, 32'h3004);
    chk("R10 irq blocked, return taken", redir_pc, 32'h3000);
    drive(5'b00001, 0, 1, 1, 0, 32'h3008);
    chk("R7 irq after return", saved_pc, 32'h3008);
    drive(5'b10000, 0, 1, 0, 0, 32'h3010);
    chk("R3 internal fault origin", 32'(cause), 32'h4);

    for (int i = 0; i < 3000; i++) begin
      logic [4:0] e;
      e = 0;
      for (int b = 0; b < 5; b++) if ($urandom_range(0, 5) == 0) e[b] = 1;
      drive(e, 1'($urandom), 1'($urandom), 1'($urandom),
            ($urandom_range(0, 3) == 0), {$urandom_range(0, 32'h3FFF_FFFF), 2'b00});
    end
    idle();
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule